// File: doc/BRIEF.md
# Haptic H-Bridge Pulse Sequencer

This block is a clocked controller for the four switch enables of a motor H-bridge. It has two modes. A level-sensitive vibrate input holds the motor in forward drive. An edge-triggered haptic input runs a timed pulse: forward, then coast with every switch open, then reverse to brake. After the pulse, a recovery window ignores further trigger edges. A trigger that arrives during vibrate takes priority. Once the pulse ends, the block goes back to forward vibrate drive.

A further output tells the regulator which voltage setpoint to use. One setting applies to the haptic pulse and the other to plain vibrate drive. Whenever the bridge swaps from one drive direction straight to the other, the block holds all switches open for a dead interval, so that no leg conducts from supply to ground. The durations come from two timing words, and the block snapshots them at the trigger edge. The block has no data stream, so every pin is a plain control or status pin.

Top module: `haptic_bridge_seq`

## Requirements
- R1: A 0-to-1 transition of `hap_trig` that is sampled at clock edge E0 starts the pulse. The phase counts are taken from `timing_a[7:0]` (forward), `timing_a[15:8]` (coast) and `timing_b[7:0]` (reverse). The bridge drives forward (`pos_hi`=1, `neg_lo`=1, others 0) for the forward count of cycles, starting at edge E0+1. The coast phase follows, and then reverse drive (`pos_lo`=1, `neg_hi`=1, others 0) for the reverse count.
- R2: In coast, all four switch enables are 0 from the first coast cycle.
- R3: A phase whose count is zero is skipped and adds no cycles to the pulse.
- R4: `busy` is 1 from edge E0 until the recovery window ends. The recovery window is 4 x `timing_b[11:8]` cycles (0 to 60) and begins right after the reverse phase.
- R5: While `busy` is 1, trigger edges have no effect. A trigger held high does not retrigger. With a zero recovery code, a new edge is accepted as soon as `busy` falls.
- R6: When no pulse phase is running and `vib_en` is 1, the bridge drives forward from the edge after `vib_en` is sampled high. Vibrate drive also resumes during recovery.
- R7: A trigger edge during vibrate runs the full pulse. Afterwards, forward vibrate drive resumes if `vib_en` is still 1.
- R8: Every direct change between forward and reverse is preceded by at least DEAD_CYC (4 by default) cycles with all switches off. A coast phase of at least that length already satisfies this rule and adds no delay. The two switches of one leg are never both on.
- R9: While `rst_n` is 0 or `chip_en` is 0, all switch enables are 0 and the inputs are ignored. `busy` is 0 from the next edge on. Reset acts at once, without waiting for a clock edge.
- R10: `vset_haptic` is 1 during the forward, coast and reverse phases, one cycle behind the phase itself, and 0 otherwise. It is 0 during vibrate drive.
- R11: When `vib_en` and `hap_trig` are both 0 and no pulse is running, all switch enables are 0.
- R12: The timing words are captured at the trigger edge. Changing them while a pulse runs does not alter that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_en | input | 1 | Block enable; 0 forces the bridge off |
| vib_en | input | 1 | Vibrate mode level input |
| hap_trig | input | 1 | Haptic pulse trigger, rising-edge sensitive |
| timing_a | input | 16 | [7:0] forward cycles, [15:8] coast cycles |
| timing_b | input | 12 | [7:0] reverse cycles, [11:8] recovery code (x4 cycles) |
| pos_hi | output | 1 | Positive leg high-side switch enable |
| pos_lo | output | 1 | Positive leg low-side switch enable |
| neg_hi | output | 1 | Negative leg high-side switch enable |
| neg_lo | output | 1 | Negative leg low-side switch enable |
| vset_haptic | output | 1 | Regulator setpoint select: 1 haptic, 0 vibrate |
| busy | output | 1 | Pulse or recovery in progress |

## Verification
The bench targets these corner cases:
- A reverse phase that follows forward with no coast. A design without the dead interval would flip straight from forward to reverse, which is shoot-through.
- Zero-length phases. A design that gets these wrong would spend a stray cycle in an empty phase.
- A trigger pulsed inside the recovery window. A design that gets this wrong would restart the pulse or extend `busy`.
- A maximum recovery code of 60 cycles. A design that gets this wrong would release `busy` early or late.
- The timing words changing during a pulse. A design that does not snapshot them would stretch or cut the pulse.
- Vibrate preempted by a trigger. The bench checks that forward drive comes back only after the dead interval, with the setpoint select back at vibrate.
- Disable and asynchronous reset in the middle of a pulse. A design that gets either wrong would leave a switch closed.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  typedef enum logic [1:0] {
    DRV_OFF = 2'd0,
    DRV_FWD = 2'd1,
    DRV_REV = 2'd2
  } drive_e;

  // Value order is the phase order; the sequencer skips forward through it.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_FWD   = 3'd1,
    PH_COAST = 3'd2,
    PH_REV   = 3'd3,
    PH_RECOV = 3'd4
  } phase_e;
endpackage

// File: rtl/hbs_edge.sv
module hbs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = en & lvl & ~lvl_q;
endmodule

// File: rtl/hbs_phase_seq.sv
module hbs_phase_seq
  import hbs_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int REC_W     = 4,
  parameter int REC_SCALE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start,
  input  logic             vib,
  input  logic [CNT_W-1:0] fwd_len,
  input  logic [CNT_W-1:0] coast_len,
  input  logic [CNT_W-1:0] rev_len,
  input  logic [REC_W-1:0] rec_code,
  output drive_e           req,
  output logic             seq_on,
  output logic             busy
);
  localparam int REC_MAX = ((1 << REC_W) - 1) * REC_SCALE;
  localparam int REC_TW  = $clog2(REC_MAX + 1);
  localparam int CW      = (CNT_W > REC_TW) ? CNT_W : REC_TW;
  localparam int NPH     = 4;

  typedef logic [NPH-1:0][CW-1:0] lens_t;
  typedef struct packed {
    phase_e        ph;
    logic [CW-1:0] cnt;
  } pick_t;

  phase_e        phase;
  logic [CW-1:0] cnt;
  lens_t         held;
  lens_t         fresh;

  assign fresh = {CW'(CW'(REC_SCALE) * CW'(rec_code)), CW'(rev_len),
                  CW'(coast_len), CW'(fwd_len)};

  // First non-empty phase at or after slot 'from'; IDLE if none remain.
  function automatic pick_t pick(input int from, input lens_t l);
    pick_t r;
    r.ph  = PH_IDLE;
    r.cnt = '0;
    for (int i = NPH - 1; i >= 0; i--) begin
      if (i >= from && l[i] != '0) begin
        r.ph  = phase_e'(3'(i + 1));
        r.cnt = l[i] - 1'b1;
      end
    end
    return r;
  endfunction

  pick_t nxt_start, nxt_step;
  assign nxt_start = pick(0, fresh);
  assign nxt_step  = pick(int'(phase), held);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      held  <= '0;
    end else if (!en) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (phase == PH_IDLE) begin
      if (start) begin
        held  <= fresh;
        phase <= nxt_start.ph;
        cnt   <= nxt_start.cnt;
      end
    end else if (cnt == '0) begin
      phase <= nxt_step.ph;
      cnt   <= nxt_step.cnt;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    unique case (phase)
      PH_FWD:   req = DRV_FWD;
      PH_COAST: req = DRV_OFF;
      PH_REV:   req = DRV_REV;
      default:  req = (vib && en) ? DRV_FWD : DRV_OFF;
    endcase
  end

  assign seq_on = (phase == PH_FWD) || (phase == PH_COAST) || (phase == PH_REV);
  assign busy   = (phase != PH_IDLE);
endmodule

// File: rtl/hbs_bridge_out.sv
module hbs_bridge_out
  import hbs_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  drive_e req,
  input  logic   seq_on,
  output logic   pos_hi,
  output logic   pos_lo,
  output logic   neg_hi,
  output logic   neg_lo,
  output logic   vset_haptic
);
  localparam int OW = $clog2(DEAD_CYC + 1);

  drive_e        cur;
  drive_e        last_dir;
  logic [OW-1:0] off_cnt;
  logic          sel_q;
  logic          dead_ok;
  logic [OW-1:0] off_inc;

  assign dead_ok = (last_dir == DRV_OFF) || (last_dir == req) ||
                   (off_cnt >= OW'(DEAD_CYC));
  assign off_inc = (off_cnt >= OW'(DEAD_CYC)) ? off_cnt : off_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur      <= DRV_OFF;
      last_dir <= DRV_OFF;
      off_cnt  <= OW'(DEAD_CYC);
      sel_q    <= 1'b0;
    end else begin
      sel_q <= en & seq_on;
      if (cur != DRV_OFF && (!en || req != cur)) begin
        cur      <= DRV_OFF;
        last_dir <= cur;
        off_cnt  <= OW'(1);
      end else if (cur == DRV_OFF) begin
        if (en && req != DRV_OFF && dead_ok) cur <= req;
        else                                 off_cnt <= off_inc;
      end
    end
  end

  assign pos_hi      = en & (cur == DRV_FWD);
  assign neg_lo      = en & (cur == DRV_FWD);
  assign pos_lo      = en & (cur == DRV_REV);
  assign neg_hi      = en & (cur == DRV_REV);
  assign vset_haptic = en & sel_q;
endmodule

// File: rtl/haptic_bridge_seq.sv
module haptic_bridge_seq
  import hbs_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int REC_W     = 4,
  parameter int REC_SCALE = 4,
  parameter int DEAD_CYC  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   chip_en,
  input  logic                   vib_en,
  input  logic                   hap_trig,
  input  logic [2*CNT_W-1:0]     timing_a,
  input  logic [CNT_W+REC_W-1:0] timing_b,
  output logic                   pos_hi,
  output logic                   pos_lo,
  output logic                   neg_hi,
  output logic                   neg_lo,
  output logic                   vset_haptic,
  output logic                   busy
);
  logic   trig_rise;
  logic   seq_on;
  drive_e req;

  hbs_edge u_edge (
    .clk (clk), .rst_n (rst_n), .en (chip_en), .lvl (hap_trig), .rise (trig_rise)
  );

  hbs_phase_seq #(
    .CNT_W (CNT_W), .REC_W (REC_W), .REC_SCALE (REC_SCALE)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (chip_en),
    .start     (trig_rise),
    .vib       (vib_en),
    .fwd_len   (timing_a[CNT_W-1:0]),
    .coast_len (timing_a[2*CNT_W-1:CNT_W]),
    .rev_len   (timing_b[CNT_W-1:0]),
    .rec_code  (timing_b[CNT_W+REC_W-1:CNT_W]),
    .req       (req),
    .seq_on    (seq_on),
    .busy      (busy)
  );

  hbs_bridge_out #(.DEAD_CYC (DEAD_CYC)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (chip_en),
    .req         (req),
    .seq_on      (seq_on),
    .pos_hi      (pos_hi),
    .pos_lo      (pos_lo),
    .neg_hi      (neg_hi),
    .neg_lo      (neg_lo),
    .vset_haptic (vset_haptic)
  );
endmodule

// File: rtl/haptic_bridge_seq_chk.sv
module haptic_bridge_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic chip_en,
  input logic hap_trig,
  input logic pos_hi,
  input logic pos_lo,
  input logic neg_hi,
  input logic neg_lo,
  input logic vset_haptic,
  input logic busy
);
  assert_leg_no_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_hi && pos_lo) && !(neg_hi && neg_lo));

  assert_fwd_then_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_hi && neg_lo) |=> !(pos_lo || neg_hi));

  assert_rev_then_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_lo && neg_hi) |=> !(pos_hi || neg_lo));

  assert_paired_legs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_hi == neg_lo) && (pos_lo == neg_hi));

  assert_off_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> !(pos_hi || pos_lo || neg_hi || neg_lo || vset_haptic));

  assert_idle_after_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> !busy);

  assert_busy_from_trigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(hap_trig) && $past(chip_en));

  assert_sel_in_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vset_haptic |-> $past(busy));
endmodule

bind haptic_bridge_seq haptic_bridge_seq_chk u_chk (
  .clk (clk), .rst_n (rst_n), .chip_en (chip_en), .hap_trig (hap_trig),
  .pos_hi (pos_hi), .pos_lo (pos_lo), .neg_hi (neg_hi), .neg_lo (neg_lo),
  .vset_haptic (vset_haptic), .busy (busy)
);

// File: tb/test_haptic_bridge_seq.sv
`timescale 1ns/1ps
module test_haptic_bridge_seq;
  localparam int DEAD = 4;
  localparam logic [3:0] FWDV = 4'b1001; // {pos_hi,pos_lo,neg_hi,neg_lo}
  localparam logic [3:0] REVV = 4'b0110;
  localparam int NV = 5;
  // {fwd, coast, rev, rec_code, vib}; coast >= DEAD in every row
  localparam logic [28:0] VEC [NV] = '{
    {8'd5,  8'd4, 8'd6,  4'd1, 1'b0},
    {8'd3,  8'd8, 8'd3,  4'd0, 1'b0},
    {8'd10, 8'd5, 8'd7,  4'd2, 1'b1},
    {8'd1,  8'd4, 8'd1,  4'd3, 1'b1},
    {8'd20, 8'd6, 8'd12, 4'd0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0, chip_en = 1'b0, vib_en = 1'b0, hap_trig = 1'b0;
  logic [15:0] timing_a = '0;
  logic [11:0] timing_b = '0;
  logic pos_hi, pos_lo, neg_hi, neg_lo, vset_haptic, busy;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  haptic_bridge_seq i_haptic_bridge_seq (
    .clk (clk), .rst_n (rst_n), .chip_en (chip_en), .vib_en (vib_en),
    .hap_trig (hap_trig), .timing_a (timing_a), .timing_b (timing_b),
    .pos_hi (pos_hi), .pos_lo (pos_lo), .neg_hi (neg_hi), .neg_lo (neg_lo),
    .vset_haptic (vset_haptic), .busy (busy)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] drv();
    return {pos_hi, pos_lo, neg_hi, neg_lo};
  endfunction

  function automatic logic [3:0] exp_drv(int t, int f, int c, int r, bit vib);
    int s  = f + c + r;
    int rs = (f > 0 && c < DEAD) ? 1 + f + DEAD : 1 + f + c;
    if (t == 0)     return vib ? FWDV : 4'b0;
    if (t < 1 + f)  return FWDV;
    if (t < rs)     return 4'b0;
    if (t < 1 + s)  return REVV;
    if (vib && t >= 1 + s + DEAD) return FWDV;
    return 4'b0;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  // One pulse; retrig_at >= 0 pulses the trigger again at that cycle,
  // mutate changes the timing words after cycle 1.
  task automatic run_seq(input string req, input int f, input int c, input int r,
                         input int rec, input bit vib, input int retrig_at, input bit mutate);
    int s = f + c + r;
    int last = s + 4 * rec + DEAD + 4;
    timing_a = {8'(c), 8'(f)};
    timing_b = {4'(rec), 8'(r)};
    vib_en = vib;
    repeat (DEAD + 4) step();
    hap_trig = 1'b1;
    for (int t = 0; t <= last; t++) begin
      step();
      chk(req, $sformatf("drive t=%0d", t), int'(drv()), int'(exp_drv(t, f, c, r, vib)));
      chk(req, $sformatf("busy t=%0d", t), int'(busy), int'(t < s + 4 * rec));
      chk("R10", $sformatf("vset t=%0d", t), int'(vset_haptic), int'(t >= 1 && t < 1 + s));
      if (t == 2) hap_trig = 1'b0;
      if (t == retrig_at) hap_trig = 1'b1;
      if (t == retrig_at + 1) hap_trig = 1'b0;
      if (mutate && t == 1) begin
        timing_a = 16'h0101;
        timing_b = 12'h001;
      end
    end
    hap_trig = 1'b0;
    vib_en = 1'b0;
    repeat (DEAD + 2) step();
  endtask

  initial begin
    #3;
    chk("R9", "reset drive", int'(drv()), 0);
    chk("R9", "reset busy", int'(busy), 0);
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R9: chip_en low ignores both inputs
    vib_en = 1'b1; hap_trig = 1'b1;
    repeat (3) begin
      step();
      chk("R9", "disabled drive", int'(drv()), 0);
      chk("R9", "disabled busy", int'(busy), 0);
    end
    chip_en = 1'b1;
    vib_en = 1'b0;
    repeat (3) begin
      step();
      chk("R9", "held trigger after enable", int'(busy), 0);
    end
    hap_trig = 1'b0;
    repeat (6) step();
    chk("R11", "standby drive", int'(drv()), 0);
    chk("R11", "standby busy", int'(busy), 0);

    // Vector table: R1, R2, R4, R6, R7
    for (int v = 0; v < NV; v++) begin
      logic [28:0] e = VEC[v];
      run_seq(e[0] ? "R7" : "R1", int'(e[28:21]), int'(e[20:13]), int'(e[12:5]),
              int'(e[4:1]), e[0], -1, 1'b0);
    end

    // R6: plain vibrate, one-cycle latency
    vib_en = 1'b1;
    step();
    chk("R6", "vibrate forward", int'(drv()), int'(FWDV));
    chk("R6", "vibrate setpoint", int'(vset_haptic), 0);
    vib_en = 1'b0;
    step();
    chk("R11", "vibrate released", int'(drv()), 0);
    repeat (DEAD + 2) step();

    run_seq("R3", 0, 0, 5, 0, 1'b0, -1, 1'b0);   // zero-length forward and coast
    run_seq("R8", 6, 0, 10, 0, 1'b0, -1, 1'b0);  // dead interval forward->reverse
    run_seq("R5", 2, 4, 2, 2, 1'b0, 10, 1'b0);   // retrigger in recovery ignored
    run_seq("R4", 1, 4, 1, 15, 1'b0, -1, 1'b0);  // 60-cycle recovery
    run_seq("R12", 5, 4, 6, 1, 1'b0, -1, 1'b1);  // timing snapshot

    // R5: zero recovery accepts an edge the cycle busy falls
    timing_a = {8'd4, 8'd2}; timing_b = {4'd0, 8'd2};
    hap_trig = 1'b1;
    step();
    hap_trig = 1'b0;
    for (int t = 1; t <= 8; t++) step();
    chk("R5", "busy low at end", int'(busy), 0);
    hap_trig = 1'b1;
    step();
    chk("R5", "immediate retrigger", int'(busy), 1);
    hap_trig = 1'b0;
    repeat (16) step();

    // R9: asynchronous reset mid pulse
    timing_a = {8'd4, 8'd8}; timing_b = {4'd1, 8'd4};
    hap_trig = 1'b1;
    repeat (4) step();
    chk("R1", "forward before reset", int'(drv()), int'(FWDV));
    rst_n = 1'b0;
    #1;
    chk("R9", "async reset drive", int'(drv()), 0);
    chk("R9", "async reset busy", int'(busy), 0);
    hap_trig = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();
    chk("R9", "idle after reset", int'(busy), 0);

    // R9: chip_en dropped mid pulse
    hap_trig = 1'b1;
    repeat (3) step();
    chip_en = 1'b0;
    #1;
    chk("R9", "disable drive", int'(drv()), 0);
    step();
    chk("R9", "disable busy", int'(busy), 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule